// File: doc/BRIEF.md
# Programmable Counter-Timer with Receive Time-Out

This block is a down-counter whose divisor comes from two CPU-written preload halves, upper and lower. It runs in one of three modes. In timer mode it produces a free-running square wave, for example a 16x baud clock for a serial port. In counter mode it performs a single countdown and raises a ready flag when the countdown completes. In time-out mode each character the receiver places in its receive FIFO restarts the countdown, so the ready flag means the receive line has been quiet for longer than the programmed interval.

The counter only moves on cycles where the count-enable tick input is high. Choosing the tick source is up to the surrounding logic, and so is turning the ready flag into an interrupt. All outputs are registered, and every input takes effect at the rising clock edge where it is sampled.

Top module: `cnt_timer`

## Requirements
- R1: A synchronous reset sets the waveform output high, the ready flag low, the count output to zero and both preload halves to zero.
- R2: A start command loads the counter with the preload value and drives the waveform high. The preload value is the upper half in the high byte and the lower half in the low byte, as held before that clock edge. A start does not clear the ready flag.
- R3: In timer mode (mode input 1), each half period of the waveform lasts N ticks, where N is the preload. On the last tick of each half period the counter reloads N and the waveform toggles. Each high-to-low toggle sets the ready flag; a low-to-high toggle leaves the flag unchanged.
- R4: In timer mode, a stop command clears the ready flag, and the counter and waveform keep running.
- R5: In counter mode (mode input 0), the counter reaches zero N ticks after start. On that tick it sets the ready flag and drives the waveform low. It then wraps to all ones and keeps counting down, with no further effect on the flag or the waveform.
- R6: In counter mode, a stop command clears the ready flag and halts the counter at its present value.
- R7: A preload of zero gives a period of 2^16 ticks, both for the countdown and for each timer half period.
- R8: The time-out-on command enters time-out mode, clears the ready flag and drives the waveform high. The counter then stays idle, and ticks do not change it, until the first character strobe.
- R9: In time-out mode, a character strobe reloads the counter with the preload and drives the waveform high. The first tick after the strobe is swallowed. On the N-th tick after that, the counter reaches zero, sets the ready flag and drives the waveform low, and the counter then stays at zero.
- R10: In time-out mode, start and stop commands have no effect on the count or on the ready flag.
- R11: A character strobe clears the ready flag. When a strobe and the expiring tick fall in the same cycle, the strobe wins: the flag stays clear and the counter reloads.
- R12: The time-out-off command leaves time-out mode with the counter halted. A later start behaves as in R2.
- R13: The count output always shows the live counter value, including the wrapped values of R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count enable, one tick per high cycle |
| mode_i | input | 1 | 1 = timer (square wave), 0 = counter (one-shot) |
| wr_hi_i | input | 1 | Write wr_data_i into the upper preload half |
| wr_lo_i | input | 1 | Write wr_data_i into the lower preload half |
| wr_data_i | input | 8 | Preload write data |
| start_i | input | 1 | Start command |
| stop_i | input | 1 | Stop command |
| tmo_on_i | input | 1 | Enter time-out mode |
| tmo_off_i | input | 1 | Leave time-out mode |
| rx_char_i | input | 1 | Strobe: a character entered the receive FIFO |
| wave_o | output | 1 | Square wave / expiry output |
| ready_o | output | 1 | Ready flag |
| count_o | output | 16 | Live counter value |

## Verification
The bench looks at the counter at the tick on which it expires, on both sides of that tick. An off-by-one reload would show up as a half period of N+1 ticks, or as ready rising a tick early.

A zero preload is run in full. A design that treats zero as "expire immediately" would raise ready after a single tick instead of after 65536.

In timer mode the bench checks that stop leaves the waveform toggling. A design that halts on stop would freeze the waveform. In counter mode it checks that stop freezes the count, and that counting continues past zero with the waveform held low.

In time-out mode the bench checks three things:
- The swallowed tick after a strobe. Without it the counter would expire one tick early.
- The strobe and the expiring tick arriving together. A design that lets expiry win would leave ready set and the count at zero.
- Start and stop while in time-out mode. A design that honours them would reload the counter or clear ready.

// File: rtl/ctt_pkg.sv
package ctt_pkg;

  typedef enum logic {
    CTT_COUNTER = 1'b0,
    CTT_TIMER   = 1'b1
  } ctt_mode_e;

  // One cycle's worth of datapath actions, chosen by the control unit.
  typedef struct packed {
    logic load;
    logic dec;
    logic wave_hi;
    logic wave_lo;
    logic wave_tog;
    logic rdy_set;
    logic rdy_clr;
  } ctt_act_t;

endpackage

// File: rtl/ctt_preload.sv
module ctt_preload #(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_hi_i,
  input  logic               wr_lo_i,
  input  logic [CNT_W/2-1:0] wr_data_i,
  output logic [CNT_W-1:0]   preload_o
);
  localparam int HALF_W = CNT_W / 2;

  logic [HALF_W-1:0] hi_q, lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (wr_hi_i) hi_q <= wr_data_i;
      if (wr_lo_i) lo_q <= wr_data_i;
    end
  end

  assign preload_o = {hi_q, lo_q};

endmodule

// File: rtl/ctt_ctrl.sv
module ctt_ctrl
  import ctt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  ctt_mode_e mode_i,
  input  logic      tick_i,
  input  logic      start_i,
  input  logic      stop_i,
  input  logic      tmo_on_i,
  input  logic      tmo_off_i,
  input  logic      rx_char_i,
  input  logic      at_one_i,
  input  logic      wave_i,
  output ctt_act_t  act_o,
  output logic      tmo_en_o,
  output logic      run_o
);
  logic tmo_q, run_q, hold_q, fired_q;
  logic tmo_d, run_d, hold_d, fired_d;
  ctt_act_t act;

  always_comb begin
    act     = '0;
    tmo_d   = tmo_q;
    run_d   = run_q;
    hold_d  = hold_q;
    fired_d = fired_q;
    if (tmo_on_i) begin
      tmo_d       = 1'b1;
      run_d       = 1'b0;
      hold_d      = 1'b0;
      act.rdy_clr = 1'b1;
      act.wave_hi = 1'b1;
    end else if (tmo_off_i) begin
      tmo_d  = 1'b0;
      run_d  = 1'b0;
      hold_d = 1'b0;
    end else if (tmo_q) begin
      if (rx_char_i) begin
        // A strobe beats a simultaneous expiry.
        act.load    = 1'b1;
        act.rdy_clr = 1'b1;
        act.wave_hi = 1'b1;
        run_d       = 1'b1;
        hold_d      = 1'b1;
      end else if (tick_i && run_q) begin
        if (hold_q) begin
          hold_d = 1'b0;
        end else begin
          act.dec = 1'b1;
          if (at_one_i) begin
            act.rdy_set = 1'b1;
            act.wave_lo = 1'b1;
            run_d       = 1'b0;
          end
        end
      end
    end else begin
      if (stop_i) begin
        act.rdy_clr = 1'b1;
        if (mode_i == CTT_COUNTER) run_d = 1'b0;
      end
      if (start_i) begin
        act.load    = 1'b1;
        act.wave_hi = 1'b1;
        run_d       = 1'b1;
        fired_d     = 1'b0;
      end else if (tick_i && run_q && !(stop_i && mode_i == CTT_COUNTER)) begin
        if (mode_i == CTT_TIMER) begin
          if (at_one_i) begin
            act.load     = 1'b1;
            act.wave_tog = 1'b1;
            if (wave_i) act.rdy_set = 1'b1;
          end else begin
            act.dec = 1'b1;
          end
        end else begin
          act.dec = 1'b1;
          if (at_one_i && !fired_q) begin
            act.rdy_set = 1'b1;
            act.wave_lo = 1'b1;
            fired_d     = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmo_q   <= 1'b0;
      run_q   <= 1'b0;
      hold_q  <= 1'b0;
      fired_q <= 1'b0;
    end else begin
      tmo_q   <= tmo_d;
      run_q   <= run_d;
      hold_q  <= hold_d;
      fired_q <= fired_d;
    end
  end

  assign act_o    = act;
  assign tmo_en_o = tmo_q;
  assign run_o    = run_q;

  // R8: a held (idle) time-out counter is not running right after the on command.
  a_r8_idle_after_on: assert property (@(posedge clk) disable iff (rst)
    tmo_on_i |=> (tmo_q && !run_q));

endmodule

// File: rtl/ctt_core.sv
module ctt_core
  import ctt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  ctt_act_t         act_i,
  input  logic [CNT_W-1:0] preload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_one_o,
  output logic             wave_o,
  output logic             ready_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             wave_q, rdy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      wave_q <= 1'b1;
      rdy_q  <= 1'b0;
    end else begin
      if (act_i.load)      cnt_q <= preload_i;
      else if (act_i.dec)  cnt_q <= cnt_q - ONE;

      if (act_i.wave_hi)       wave_q <= 1'b1;
      else if (act_i.wave_lo)  wave_q <= 1'b0;
      else if (act_i.wave_tog) wave_q <= ~wave_q;

      if (act_i.rdy_clr)      rdy_q <= 1'b0;
      else if (act_i.rdy_set) rdy_q <= 1'b1;
    end
  end

  assign cnt_o    = cnt_q;
  assign at_one_o = (cnt_q == ONE);
  assign wave_o   = wave_q;
  assign ready_o  = rdy_q;

  // R3/R5: a falling waveform comes with ready, unless a clear was requested.
  a_r3_fall_sets_ready: assert property (@(posedge clk) disable iff (rst)
    $fell(wave_q) |-> (rdy_q || $past(act_i.rdy_clr)));

endmodule

// File: rtl/cnt_timer.sv
module cnt_timer
  import ctt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_i,
  input  logic               mode_i,
  input  logic               wr_hi_i,
  input  logic               wr_lo_i,
  input  logic [CNT_W/2-1:0] wr_data_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               tmo_on_i,
  input  logic               tmo_off_i,
  input  logic               rx_char_i,
  output logic               wave_o,
  output logic               ready_o,
  output logic [CNT_W-1:0]   count_o
);
  logic [CNT_W-1:0] preload_w;
  ctt_act_t         act_w;
  logic             at_one_w, tmo_en_w, run_w;
  ctt_mode_e        mode_w;

  assign mode_w = ctt_mode_e'(mode_i);

  ctt_preload #(.CNT_W(CNT_W)) u_preload (
    .clk(clk), .rst(rst), .wr_hi_i(wr_hi_i), .wr_lo_i(wr_lo_i),
    .wr_data_i(wr_data_i), .preload_o(preload_w)
  );

  ctt_ctrl u_ctrl (
    .clk(clk), .rst(rst), .mode_i(mode_w), .tick_i(tick_i),
    .start_i(start_i), .stop_i(stop_i), .tmo_on_i(tmo_on_i),
    .tmo_off_i(tmo_off_i), .rx_char_i(rx_char_i), .at_one_i(at_one_w),
    .wave_i(wave_o), .act_o(act_w), .tmo_en_o(tmo_en_w), .run_o(run_w)
  );

  ctt_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .act_i(act_w), .preload_i(preload_w),
    .cnt_o(count_o), .at_one_o(at_one_w), .wave_o(wave_o), .ready_o(ready_o)
  );

  logic no_tmo_cmd;
  assign no_tmo_cmd = !tmo_on_i && !tmo_off_i;

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (count_o == '0 && wave_o && !ready_o));

  a_r6_stop_halts: assert property (@(posedge clk) disable iff (rst)
    (!tmo_en_w && mode_w == CTT_COUNTER && stop_i && !start_i && no_tmo_cmd)
      |=> (!ready_o && $stable(count_o)));

  a_r8_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (tmo_en_w && !run_w && !rx_char_i && no_tmo_cmd) |=> $stable(count_o));

  a_r8_on_clears: assert property (@(posedge clk) disable iff (rst)
    tmo_on_i |=> (!ready_o && wave_o));

  a_r10_cmds_ignored: assert property (@(posedge clk) disable iff (rst)
    (tmo_en_w && (start_i || stop_i) && !rx_char_i && !tick_i && no_tmo_cmd)
      |=> ($stable(count_o) && $stable(ready_o)));

  a_r11_strobe_wins: assert property (@(posedge clk) disable iff (rst)
    (tmo_en_w && rx_char_i && no_tmo_cmd)
      |=> (!ready_o && count_o == $past(preload_w)));

endmodule

// File: tb/test_cnt_timer.sv
module test_cnt_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 0, mode = 0, wr_hi = 0, wr_lo = 0;
  logic [7:0]  wr_data = '0;
  logic        start = 0, stop = 0, tmo_on = 0, tmo_off = 0, rx_char = 0;
  logic        wave, ready;
  logic [15:0] count;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  cnt_timer i_cnt_timer (
    .clk(clk), .rst(rst), .tick_i(tick), .mode_i(mode), .wr_hi_i(wr_hi),
    .wr_lo_i(wr_lo), .wr_data_i(wr_data), .start_i(start), .stop_i(stop),
    .tmo_on_i(tmo_on), .tmo_off_i(tmo_off), .rx_char_i(rx_char),
    .wave_o(wave), .ready_o(ready), .count_o(count)
  );

  // {mode, preload, ticks, exp_wave, exp_ready, exp_count}
  localparam int NV = 10;
  localparam logic [42:0] VEC [0:NV-1] = '{
    {1'b1, 16'd3,   8'd2,   1'b1, 1'b0, 16'd1},      // R3
    {1'b1, 16'd3,   8'd3,   1'b0, 1'b1, 16'd3},      // R3
    {1'b1, 16'd3,   8'd5,   1'b0, 1'b1, 16'd1},      // R3
    {1'b1, 16'd3,   8'd6,   1'b1, 1'b1, 16'd3},      // R3
    {1'b1, 16'd1,   8'd1,   1'b0, 1'b1, 16'd1},      // R3
    {1'b1, 16'd1,   8'd2,   1'b1, 1'b1, 16'd1},      // R3
    {1'b0, 16'd4,   8'd3,   1'b1, 1'b0, 16'd1},      // R5 R13
    {1'b0, 16'd4,   8'd4,   1'b0, 1'b1, 16'd0},      // R5
    {1'b0, 16'd4,   8'd6,   1'b0, 1'b1, 16'hFFFE},   // R5 R13
    {1'b0, 16'd300, 8'd100, 1'b1, 1'b0, 16'd200}     // R2 R13
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic pulse_start();   start = 1;   cyc(); start = 0;   endtask
  task automatic pulse_stop();    stop = 1;    cyc(); stop = 0;    endtask
  task automatic pulse_tmo_on();  tmo_on = 1;  cyc(); tmo_on = 0;  endtask
  task automatic pulse_tmo_off(); tmo_off = 1; cyc(); tmo_off = 0; endtask
  task automatic pulse_rx();      rx_char = 1; cyc(); rx_char = 0; endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      tick = 1;
      repeat (n) cyc();
      tick = 0;
    end
  endtask

  task automatic set_preload(input logic [15:0] v);
    wr_hi = 1; wr_data = v[15:8]; cyc(); wr_hi = 0;
    wr_lo = 1; wr_data = v[7:0];  cyc(); wr_lo = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst = 0;
    // R1: reset state
    chk("R1 wave", wave, 1);
    chk("R1 ready", ready, 0);
    chk("R1 count", count, 0);

    // Vector table: R2 R3 R5 R13
    for (int v = 0; v < NV; v++) begin
      mode = VEC[v][42];
      pulse_stop();
      set_preload(VEC[v][41:26]);
      pulse_start();
      ticks(int'(VEC[v][25:18]));
      chk($sformatf("R3/R5 vec%0d wave", v), wave, VEC[v][17]);
      chk($sformatf("R3/R5 vec%0d ready", v), ready, VEC[v][16]);
      chk($sformatf("R13 vec%0d count", v), count, VEC[v][15:0]);
    end

    // R2: start does not clear ready
    mode = 0; pulse_stop(); set_preload(16'd2); pulse_start(); ticks(2);
    chk("R2 ready before", ready, 1);
    pulse_start();
    chk("R2 ready kept", ready, 1);
    chk("R2 reload", count, 2);
    chk("R2 wave high", wave, 1);

    // R4: timer stop clears ready, wave keeps running
    mode = 1; pulse_stop(); set_preload(16'd2); pulse_start(); ticks(2);
    chk("R4 ready set", ready, 1);
    pulse_stop();
    chk("R4 ready cleared", ready, 0);
    chk("R4 wave low", wave, 0);
    ticks(2);
    chk("R4 wave toggles", wave, 1);
    chk("R4 ready stays", ready, 0);
    ticks(2);
    chk("R4 wave falls again", wave, 0);
    chk("R4 ready resets", ready, 1);

    // R6: counter stop halts and clears
    mode = 0; pulse_stop(); set_preload(16'd10); pulse_start(); ticks(3);
    chk("R6 count pre", count, 7);
    pulse_stop();
    ticks(3);
    chk("R6 halted", count, 7);
    chk("R6 ready", ready, 0);

    // R7: zero preload is 65536 ticks
    mode = 0; pulse_stop(); set_preload(16'd0); pulse_start(); ticks(1);
    chk("R7 wrap", count, 16'hFFFF);
    ticks(65534);
    chk("R7 count one", count, 1);
    chk("R7 not ready", ready, 0);
    ticks(1);
    chk("R7 count zero", count, 0);
    chk("R7 ready", ready, 1);
    chk("R7 wave low", wave, 0);

    // R8: time-out on clears ready and idles
    set_preload(16'd5);
    pulse_tmo_on();
    chk("R8 ready cleared", ready, 0);
    chk("R8 wave high", wave, 1);
    ticks(4);
    chk("R8 idle count", count, 0);

    // R9: strobe reloads, first tick swallowed, expiry after N more
    pulse_rx();
    chk("R9 reload", count, 5);
    ticks(1);
    chk("R9 swallowed tick", count, 5);
    ticks(4);
    chk("R9 count one", count, 1);
    chk("R9 not yet", ready, 0);
    ticks(1);
    chk("R9 expired", ready, 1);
    chk("R9 wave low", wave, 0);
    chk("R9 count zero", count, 0);
    ticks(3);
    chk("R9 stays zero", count, 0);

    // R10: start and stop ignored in time-out mode
    pulse_start();
    chk("R10 start ignored", count, 0);
    pulse_stop();
    chk("R10 stop ignored", ready, 1);

    // R11: strobe after expiry clears ready
    pulse_rx();
    chk("R11 ready cleared", ready, 0);
    chk("R11 reload", count, 5);
    ticks(5);
    chk("R11 at one", count, 1);
    // R11: strobe and expiring tick together: strobe wins
    tick = 1; rx_char = 1; cyc(); tick = 0; rx_char = 0;
    chk("R11 same-tick ready", ready, 0);
    chk("R11 same-tick count", count, 5);

    // R12: leave time-out mode, halted, then normal start
    pulse_tmo_off();
    ticks(3);
    chk("R12 halted", count, 5);
    mode = 0; set_preload(16'd3); pulse_start(); ticks(2);
    chk("R12 normal count", count, 1);
    ticks(1);
    chk("R12 normal expiry", ready, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule